// File: doc/BRIEF.md
# Seven-Bit Stream Unpacker and Packer

This block converts between ordinary 8-bit payload bytes and the 7-bit-clean byte form used on a serial control link, where the top bit of every link byte must stay clear. It has two independent streaming channels. The unpack channel takes link bytes and rebuilds payload bytes. The pack channel does the reverse. Each channel has a valid/ready input, a valid/ready output and a last flag that frames a message. Neither channel stores a whole message. Each holds only the bits of one partly built byte and a single output register.

The bit layout spreads the carry bits across neighbouring bytes instead of collecting them into one header byte. Link bytes are counted in slots 0 to 7 within a group of eight. Link byte 0 of a group opens a payload byte with its seven bits. Link byte k (1 to 7) completes the open byte by supplying its top k bits from the link byte's low k bits. The rest of that link byte, shifted right by k, opens the next payload byte. At k = 7 nothing remains, so eight link bytes rebuild exactly seven payload bytes. An equivalent view: the seven-bit values are laid end to end, least significant bit first, and the result is cut into 8-bit bytes.

Top module: `sevbit_codec`

## Requirements
- R1: After reset, both output valids are low and both input readies are high. A reset in the middle of a message discards it, and the next link byte on the unpack channel is treated as slot 0.
- R2: Unpack channel, slot 0 and slots 1 to 6: the output bytes equal the link bytes' seven-bit values laid end to end LSB first and cut into 8-bit bytes. A payload byte is emitted as soon as it is complete.
- R3: Unpack channel, slot 7: it fills bits 7:1 of the open byte, opens no new byte, and the next link byte starts a new group at slot 0.
- R4: Bit 7 of every unpack-channel input byte has no effect on any output.
- R5: For a message of n link bytes where n mod 8 is not 1, the unpack channel emits exactly n - floor((n+7)/8) bytes. The last flag is set on the final byte only, and a partly filled byte left at the end is dropped.
- R6: When a message ends on a slot-0 byte (n mod 8 = 1), that byte's seven bits are emitted as a final zero-padded byte with the last flag set.
- R7: Pack channel: the output bytes are the payload's bits laid end to end LSB first and cut into 7-bit values. Bit 7 of every output byte is 0.
- R8: For m payload bytes, the pack channel emits m + ceil(m/7) bytes. The final byte carries the leftover bits, zero-padded, and is the only byte with the last flag set. While the pack channel emits a carry-only byte, its input ready is low.
- R9: Packing any byte sequence and then unpacking the result gives back the original sequence with the same length.
- R10: While an output is valid and not ready, its data and last stay unchanged and that channel's input ready is low. Stalls lose and duplicate no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| unp_in_valid | input | 1 | Link byte offered to the unpack channel |
| unp_in_ready | output | 1 | Unpack channel accepts the byte |
| unp_in_data | input | 8 | Link byte; bit 7 ignored |
| unp_in_last | input | 1 | Final link byte of the message |
| unp_out_valid | output | 1 | Rebuilt payload byte available |
| unp_out_ready | input | 1 | Consumer takes the payload byte |
| unp_out_data | output | 8 | Rebuilt payload byte |
| unp_out_last | output | 1 | Final payload byte of the message |
| pak_in_valid | input | 1 | Payload byte offered to the pack channel |
| pak_in_ready | output | 1 | Pack channel accepts the byte |
| pak_in_data | input | 8 | Payload byte |
| pak_in_last | input | 1 | Final payload byte of the message |
| pak_out_valid | output | 1 | Link byte available |
| pak_out_ready | input | 1 | Consumer takes the link byte |
| pak_out_data | output | 8 | Link byte, bit 7 always 0 |
| pak_out_last | output | 1 | Final link byte of the message |

## Verification
A wrong slot count or a stale carry register shows on the very next byte that is emitted. The byte comes out with bits moved or mixed in from the previous byte, so a comparison against the bit-concatenation model catches it within one group of eight. A wrong end-of-message rule shows as a missing or extra byte, or a misplaced last flag, right after the final input. The bench therefore counts the bytes for each length class and then watches the idle output for strays. Back-pressure faults appear only when the consumer stalls, so random ready patterns are combined with input gaps, and a round trip catches any byte that is lost or repeated.

// File: rtl/sevbit_pkg.sv
`timescale 1ns/1ps
package sevbit_pkg;
  localparam int BYTE_W    = 8;
  localparam int NARROW_W  = 7;
  localparam int GROUP_LEN = 8;
  localparam int SLOT_W    = $clog2(GROUP_LEN);

  typedef logic [BYTE_W-1:0]   byte_t;
  typedef logic [NARROW_W-1:0] narrow_t;
  typedef logic [SLOT_W-1:0]   slot_t;

  localparam slot_t LAST_SLOT = slot_t'(GROUP_LEN - 1);
endpackage

// File: rtl/sevbit_rst_sync.sv
`timescale 1ns/1ps
module sevbit_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sevbit_outreg.sv
`timescale 1ns/1ps
module sevbit_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         ld_last,
  input  logic         out_ready,
  output logic         free,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_last
);
  logic         vld_q, vld_d;
  logic [W-1:0] dat_q;
  logic         lst_q;

  assign free = !vld_q || out_ready;

  always_comb begin
    vld_d = vld_q;
    if (load)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      dat_q <= ld_data;
      lst_q <= ld_last;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_last  = lst_q;
endmodule

// File: rtl/sevbit_unpack.sv
`timescale 1ns/1ps
module sevbit_unpack
  import sevbit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  byte_t in_data,
  input  logic  in_last,
  output logic  in_ready,
  input  logic  slot_free,
  output logic  load,
  output byte_t ld_data,
  output logic  ld_last
);
  slot_t  slot_q, slot_d;
  byte_t  acc_q, acc_d;
  logic   take;
  byte_t  word, spill;
  logic   [SLOT_W:0] shamt;
  logic   unused_msb;

  assign unused_msb = in_data[BYTE_W-1];
  assign in_ready   = slot_free;
  assign take       = in_valid && in_ready;

  always_comb begin
    word    = {1'b0, in_data[NARROW_W-1:0]};
    shamt   = (SLOT_W+1)'(BYTE_W) - {1'b0, slot_q};
    spill   = word << shamt;
    slot_d  = slot_q;
    acc_d   = acc_q;
    load    = 1'b0;
    ld_data = word;
    ld_last = in_last;
    if (take) begin
      slot_d = in_last ? '0 : slot_q + 1'b1;
      if (slot_q == '0) begin
        // open a new byte; emitted only as a lone message tail
        acc_d = word;
        load  = in_last;
      end else begin
        // low bits close the open byte, the rest opens the next one
        load    = 1'b1;
        ld_data = acc_q | spill;
        acc_d   = word >> slot_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  always_ff @(posedge clk) begin
    if (take) acc_q <= acc_d;
  end
endmodule

// File: rtl/sevbit_pack.sv
`timescale 1ns/1ps
module sevbit_pack
  import sevbit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  byte_t in_data,
  input  logic  in_last,
  output logic  in_ready,
  input  logic  slot_free,
  output logic  load,
  output byte_t ld_data,
  output logic  ld_last
);
  slot_t   slot_q, slot_d;
  narrow_t carry_q, carry_d;
  logic    tail_q, tail_d;
  logic    flush, take;
  narrow_t shl, shr;

  assign flush    = (slot_q == LAST_SLOT) || tail_q;
  assign in_ready = slot_free && !flush;
  assign take     = in_valid && in_ready;

  always_comb begin
    shl     = narrow_t'(in_data << slot_q);
    shr     = narrow_t'(in_data >> (NARROW_W - int'(slot_q)));
    slot_d  = slot_q;
    carry_d = carry_q;
    tail_d  = tail_q;
    load    = 1'b0;
    ld_data = {1'b0, carry_q};
    ld_last = tail_q;
    if (flush && slot_free) begin
      // carry-only byte: end of group or end of message
      load    = 1'b1;
      slot_d  = '0;
      carry_d = '0;
      tail_d  = 1'b0;
    end else if (take) begin
      load    = 1'b1;
      ld_data = {1'b0, carry_q | shl};
      ld_last = 1'b0;
      carry_d = shr;
      slot_d  = slot_q + 1'b1;
      tail_d  = in_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      carry_q <= '0;
      tail_q  <= 1'b0;
    end else begin
      slot_q  <= slot_d;
      carry_q <= carry_d;
      tail_q  <= tail_d;
    end
  end
endmodule

// File: rtl/sevbit_codec.sv
`timescale 1ns/1ps
module sevbit_codec
  import sevbit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       unp_in_valid,
  output logic       unp_in_ready,
  input  logic [7:0] unp_in_data,
  input  logic       unp_in_last,
  output logic       unp_out_valid,
  input  logic       unp_out_ready,
  output logic [7:0] unp_out_data,
  output logic       unp_out_last,
  input  logic       pak_in_valid,
  output logic       pak_in_ready,
  input  logic [7:0] pak_in_data,
  input  logic       pak_in_last,
  output logic       pak_out_valid,
  input  logic       pak_out_ready,
  output logic [7:0] pak_out_data,
  output logic       pak_out_last
);
  logic  srst_n;
  logic  u_free, u_load, u_last;
  byte_t u_data;
  logic  p_free, p_load, p_last;
  byte_t p_data;

  sevbit_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  sevbit_unpack u_unp (
    .clk(clk), .rst_n(srst_n),
    .in_valid(unp_in_valid), .in_data(unp_in_data), .in_last(unp_in_last),
    .in_ready(unp_in_ready), .slot_free(u_free),
    .load(u_load), .ld_data(u_data), .ld_last(u_last)
  );

  sevbit_outreg #(.W(BYTE_W)) u_unp_out (
    .clk(clk), .rst_n(srst_n), .load(u_load), .ld_data(u_data),
    .ld_last(u_last), .out_ready(unp_out_ready), .free(u_free),
    .out_valid(unp_out_valid), .out_data(unp_out_data), .out_last(unp_out_last)
  );

  sevbit_pack u_pak (
    .clk(clk), .rst_n(srst_n),
    .in_valid(pak_in_valid), .in_data(pak_in_data), .in_last(pak_in_last),
    .in_ready(pak_in_ready), .slot_free(p_free),
    .load(p_load), .ld_data(p_data), .ld_last(p_last)
  );

  sevbit_outreg #(.W(BYTE_W)) u_pak_out (
    .clk(clk), .rst_n(srst_n), .load(p_load), .ld_data(p_data),
    .ld_last(p_last), .out_ready(pak_out_ready), .free(p_free),
    .out_valid(pak_out_valid), .out_data(pak_out_data), .out_last(pak_out_last)
  );
endmodule

// File: rtl/sevbit_codec_chk.sv
`timescale 1ns/1ps
module sevbit_codec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       unp_in_valid,
  input logic       unp_in_ready,
  input logic [7:0] unp_in_data,
  input logic       unp_in_last,
  input logic       unp_out_valid,
  input logic       unp_out_ready,
  input logic [7:0] unp_out_data,
  input logic       unp_out_last,
  input logic       pak_in_valid,
  input logic       pak_in_ready,
  input logic [7:0] pak_in_data,
  input logic       pak_in_last,
  input logic       pak_out_valid,
  input logic       pak_out_ready,
  input logic [7:0] pak_out_data,
  input logic       pak_out_last
);
  p_unp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unp_out_valid && !unp_out_ready |=>
      unp_out_valid && $stable(unp_out_data) && $stable(unp_out_last));

  p_pak_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pak_out_valid && !pak_out_ready |=>
      pak_out_valid && $stable(pak_out_data) && $stable(pak_out_last));

  p_unp_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unp_out_valid && !unp_out_ready |-> !unp_in_ready);

  p_pak_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pak_out_valid && !pak_out_ready |-> !pak_in_ready);

  p_pak_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pak_out_valid |-> !pak_out_data[7]);

  p_pak_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pak_in_valid && pak_in_ready && pak_in_last |=> !pak_in_ready);

  p_unp_lastout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    unp_in_valid && unp_in_ready && unp_in_last |=> unp_out_valid && unp_out_last);
endmodule

bind sevbit_codec sevbit_codec_chk u_chk (.*);

// File: tb/sevbit_codec_tb.sv
`timescale 1ns/1ps
module sevbit_codec_tb;
  logic       clk;
  logic       rst_n;
  logic       unp_in_valid, unp_in_ready, unp_in_last;
  logic [7:0] unp_in_data;
  logic       unp_out_valid, unp_out_ready, unp_out_last;
  logic [7:0] unp_out_data;
  logic       pak_in_valid, pak_in_ready, pak_in_last;
  logic [7:0] pak_in_data;
  logic       pak_out_valid, pak_out_ready, pak_out_last;
  logic [7:0] pak_out_data;

  int n_chk;
  int n_fail;
  logic [7:0] src  [0:127];
  logic [7:0] orig [0:127];
  logic [7:0] got  [0:127];
  logic [7:0] keep [0:127];
  logic       gotl [0:127];
  logic [7:0] expd [0:127];
  int got_n;
  int exp_n;

  sevbit_codec u_dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  // unpack reference: seven-bit values end to end, cut into bytes
  function automatic void model_unp(input int n);
    int nb;
    nb = (7 * n) / 8;
    for (int o = 0; o < nb; o++)
      for (int b = 0; b < 8; b++)
        expd[o][b] = src[(o*8+b)/7][(o*8+b)%7];
    if (n % 8 == 1) begin
      expd[nb] = {1'b0, src[n-1][6:0]};
      nb++;
    end
    exp_n = nb;
  endfunction

  // pack reference: payload bits end to end, cut into seven-bit values
  function automatic void model_pak(input int m);
    int nb;
    nb = (8 * m + 6) / 7;
    for (int o = 0; o < nb; o++) begin
      expd[o] = 8'h00;
      for (int b = 0; b < 7; b++)
        if (o*7+b < 8*m) expd[o][b] = src[(o*7+b)/8][(o*7+b)%8];
    end
    exp_n = nb;
  endfunction

  task automatic send_stream(input bit pk, input int n, input int gap, input bit with_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pk) begin
        pak_in_valid = 1'b1; pak_in_data = src[i]; pak_in_last = with_last && (i == n-1);
      end else begin
        unp_in_valid = 1'b1; unp_in_data = src[i]; unp_in_last = with_last && (i == n-1);
      end
      #1;
      while (!(pk ? pak_in_ready : unp_in_ready)) begin
        @(negedge clk); #1;
      end
      @(posedge clk);
      if (gap > 0) begin
        @(negedge clk);
        pak_in_valid = 1'b0; unp_in_valid = 1'b0;
        for (int g = 1; g < gap; g++) @(negedge clk);
      end
    end
    @(negedge clk);
    pak_in_valid = 1'b0; unp_in_valid = 1'b0;
    pak_in_last  = 1'b0; unp_in_last  = 1'b0;
  endtask

  task automatic collect(input bit pk, input bit bp);
    int cyc;
    int extra;
    got_n = 0;
    cyc   = 0;
    while (got_n < exp_n && cyc < 4000) begin
      @(posedge clk); #1;
      if (pk) pak_out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
      else    unp_out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
      @(negedge clk);
      if (pk ? (pak_out_valid && pak_out_ready) : (unp_out_valid && unp_out_ready)) begin
        got[got_n]  = pk ? pak_out_data : unp_out_data;
        gotl[got_n] = pk ? pak_out_last : unp_out_last;
        got_n++;
      end
      cyc++;
    end
    @(posedge clk); #1;
    pak_out_ready = 1'b1; unp_out_ready = 1'b1;
    extra = 0;
    repeat (12) begin
      @(negedge clk);
      if (pk ? pak_out_valid : unp_out_valid) extra++;
    end
    chk(extra == 0, pk ? "R8" : "R5", "stray output bytes", extra, 0);
  endtask

  task automatic check_stream(input bit pk, input string req);
    chk(got_n == exp_n, req, "byte count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got[i] == expd[i], req, $sformatf("data[%0d]", i), got[i], expd[i]);
      chk(gotl[i] == (i == exp_n-1), req, $sformatf("last[%0d]", i), gotl[i], i == exp_n-1);
      if (pk) chk(got[i][7] == 1'b0, "R7", $sformatf("msb[%0d]", i), got[i][7], 0);
    end
  endtask

  task automatic run(input bit pk, input int n, input int gap, input bit bp, input string req);
    if (pk) model_pak(n); else model_unp(n);
    fork
      send_stream(pk, n, gap, 1'b1);
      collect(pk, bp);
    join
    check_stream(pk, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(unp_out_valid == 1'b0, "R1", "unp_out_valid after reset", unp_out_valid, 0);
    chk(pak_out_valid == 1'b0, "R1", "pak_out_valid after reset", pak_out_valid, 0);
    chk(unp_in_ready == 1'b1, "R1", "unp_in_ready after reset", unp_in_ready, 1);
    chk(pak_in_ready == 1'b1, "R1", "pak_in_ready after reset", pak_in_ready, 1);
  endtask

  task automatic t_reset_mid();
    unp_out_ready = 1'b0;
    src[0] = 8'h55; src[1] = 8'h2A;
    send_stream(1'b0, 2, 0, 1'b0);
    do_reset();
    chk(unp_out_valid == 1'b0, "R1", "output dropped by reset", unp_out_valid, 0);
    for (int i = 0; i < 8; i++) src[i] = 8'(8'h11 * (i + 1)) & 8'h7F;
    run(1'b0, 8, 0, 1'b0, "R1");
  endtask

  task automatic t_unp_group();
    int n0;
    for (int i = 0; i < 8; i++) src[i] = 8'(8'h13 * i + 8'h21) | ((i % 2 == 1) ? 8'h80 : 8'h00);
    run(1'b0, 8, 0, 1'b0, "R2,R3");
    n0 = got_n;
    for (int i = 0; i < n0; i++) keep[i] = got[i];
    for (int i = 0; i < 8; i++) src[i] = src[i] & 8'h7F;
    run(1'b0, 8, 1, 1'b0, "R2,R3");
    chk(got_n == n0, "R4", "count with msb set vs clear", got_n, n0);
    for (int i = 0; i < n0; i++)
      chk(got[i] == keep[i], "R4", $sformatf("byte %0d msb ignored", i), keep[i], got[i]);
    for (int i = 0; i < 16; i++) src[i] = 8'($urandom);
    run(1'b0, 16, 0, 1'b0, "R3");
  endtask

  task automatic t_unp_lengths();
    int lens [6] = '{2, 3, 5, 7, 15, 16};
    foreach (lens[j]) begin
      for (int i = 0; i < lens[j]; i++) src[i] = 8'($urandom);
      run(1'b0, lens[j], j % 2, 1'b0, "R5");
      chk(got_n == lens[j] - (lens[j] + 7) / 8, "R5", "count formula", got_n,
          lens[j] - (lens[j] + 7) / 8);
    end
  endtask

  task automatic t_unp_tail();
    src[0] = 8'hE5;
    run(1'b0, 1, 0, 1'b0, "R6");
    chk(got_n == 1 && got[0] == 8'h65, "R6", "lone byte", got[0], 8'h65);
    for (int i = 0; i < 9; i++) src[i] = 8'($urandom);
    run(1'b0, 9, 0, 1'b0, "R6");
  endtask

  task automatic t_pak();
    int lens [5] = '{1, 6, 7, 8, 13};
    foreach (lens[j]) begin
      for (int i = 0; i < lens[j]; i++) src[i] = 8'($urandom);
      run(1'b1, lens[j], j % 2, 1'b0, "R7,R8");
      chk(got_n == lens[j] + (lens[j] + 6) / 7, "R8", "count formula", got_n,
          lens[j] + (lens[j] + 6) / 7);
    end
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < 24; i++) src[i] = 8'($urandom);
    run(1'b0, 24, 1, 1'b1, "R10");
    for (int i = 0; i < 20; i++) src[i] = 8'($urandom);
    run(1'b1, 20, 0, 1'b1, "R10");
  endtask

  task automatic t_roundtrip();
    for (int it = 0; it < 6; it++) begin
      int m;
      m = 1 + int'($urandom % 40);
      for (int i = 0; i < m; i++) begin
        src[i]  = 8'($urandom);
        orig[i] = src[i];
      end
      run(1'b1, m, it % 2, it > 2, "R9");
      for (int i = 0; i < got_n; i++) src[i] = got[i];
      run(1'b0, got_n, 0, it > 3, "R9");
      chk(got_n == m, "R9", "round trip length", got_n, m);
      for (int i = 0; i < m && i < got_n; i++)
        chk(got[i] == orig[i], "R9", $sformatf("round trip byte %0d", i), got[i], orig[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    unp_in_valid = 1'b0; unp_in_data = 8'h00; unp_in_last = 1'b0; unp_out_ready = 1'b0;
    pak_in_valid = 1'b0; pak_in_data = 8'h00; pak_in_last = 1'b0; pak_out_ready = 1'b0;
    t_reset();
    t_reset_mid();
    t_unp_group();
    t_unp_lengths();
    t_unp_tail();
    t_pak();
    t_backpressure();
    t_roundtrip();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule